// File: doc/BRIEF.md
# Round-to-Odd Double-to-Single Narrowing Converter

This block narrows an IEEE-754 binary64 operand to binary32 with round-to-odd rounding. The magnitude is first cut toward zero. If any of the discarded precision was nonzero, the least significant bit of the narrowed result is forced to 1. A value narrowed this way can later be rounded a second time to a shorter format without the error of double rounding. The block has no rounding-mode input, so nothing outside it can change how it rounds.

One operand can enter per cycle with a valid strobe, and its result leaves exactly two cycles later. Each conversion can raise four exception conditions. These are ORed into a sticky status register, which only reset or an explicit clear pulse empties. All input classes are handled: zeros, infinities, quiet and signalling NaNs, normals that stay normal, normals that overflow the single-precision range, values that land in the single-precision subnormal range, and double-precision subnormals.

Top module: `narrow_rto_conv`

## Requirements
- R1: For every cycle with `in_valid` high, `out_valid` is high for exactly one cycle two clock edges later, and `out_valid` is never high otherwise. Back-to-back operands give back-to-back results in order.
- R2: An input that stays in the single-precision normal range gives its exponent rebiased, its top 23 fraction bits, and bit 0 ORed with "any lower fraction bit set". The inexact flag is raised exactly when that OR is 1.
- R3: An input whose magnitude is 2^128 or more (and finite) gives 0x7F7FFFFF with the input's sign, and raises overflow and inexact.
- R4: An input with a magnitude below 2^-126 and a nonzero double-precision exponent gives a single-precision subnormal. That result is the significand shifted right, with bit 0 ORed with "any shifted-out bit set". Lost bits raise underflow and inexact. An exact result raises no flag.
- R5: A double-precision subnormal input gives 0x00000001 with its sign, and raises underflow and inexact.
- R6: A zero or an infinity gives a zero or an infinity of the same sign, with no flag raised.
- R7: A NaN gives exponent all ones, with fraction bit 22 set and fraction bits 21:0 equal to input fraction bits 50:29, and the sign is kept. A signalling input (input fraction bit 51 clear) raises invalid. A quiet input raises no flag.
- R8: The sticky status `flags` has the layout bit 3 invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact. A completing conversion ORs its flags in, and a conversion never clears a bit.
- R9: A `flag_clear` pulse empties `flags`. If a conversion completes at the same edge, `flags` afterwards holds that conversion's flags alone.
- R10: After reset, `out_valid` is 0, `out_data` is 0 and `flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | binary64 operand |
| flag_clear | input | 1 | Empties the sticky status register |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_data | output | 32 | binary32 result |
| flags | output | 4 | Sticky status: invalid, overflow, underflow, inexact (bits 3..0) |

## Verification
The checker assumes that `rst` is high at the first clock edge, so it never reads the pipeline before it has been reset. It also assumes that `flag_clear` is the only way the sticky register is emptied outside reset. Every test drives its inputs on the falling edge and samples outputs there. The bench pulses `flag_clear` only while no conversion is in flight, except in the single case written to hit the same-edge rule, so each test sees one expected flag pattern. Operands are picked at the exponent boundaries: largest finite single, 2^128, 2^-126, 2^-127, 2^-149 and 2^-150.

// File: rtl/rto_pkg.sv
package rto_pkg;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int FLAG_W     = 4;

  // status bit positions
  localparam int FLG_INX = 0;
  localparam int FLG_UDF = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_INV = 3;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_INF  = 3'd1,
    CLS_NAN  = 3'd2,
    CLS_NORM = 3'd3,
    CLS_SUB  = 3'd4,
    CLS_OVF  = 3'd5
  } rto_cls_e;
endpackage

// File: rtl/rto_classify.sv
// Stage 1: split the operand, sort it into a result class and
// precompute exponent and denormalising shift.
module rto_classify
  import rto_pkg::*;
#(
  parameter int IEW  = DBL_EXP_W,
  parameter int IFW  = DBL_FRAC_W,
  parameter int OEW  = SGL_EXP_W,
  parameter int OFW  = SGL_FRAC_W,
  parameter int SH_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [IEW+IFW:0]      in_data,
  output logic                  s1_valid,
  output logic                  s1_sign,
  output rto_cls_e              s1_cls,
  output logic [OEW-1:0]        s1_exp,
  output logic [IFW:0]          s1_sig,
  output logic [SH_W-1:0]       s1_shift,
  output logic                  s1_snan
);
  localparam int BIAS_IN   = (1 << (IEW - 1)) - 1;
  localparam int BIAS_OUT  = (1 << (OEW - 1)) - 1;
  localparam int BIAS_DIFF = BIAS_IN - BIAS_OUT;
  localparam int OVF_E     = BIAS_DIFF + (1 << OEW) - 1;
  localparam int SH_BASE   = BIAS_DIFF + 1 + IFW - OFW;
  localparam int SH_MAX    = (1 << SH_W) - 1;

  logic             sign_c;
  logic [IEW-1:0]   exp_c;
  logic [IFW-1:0]   frac_c;
  logic [IEW:0]     sh_full;
  logic [SH_W-1:0]  sh_c;
  rto_cls_e         cls_c;

  assign sign_c  = in_data[IEW+IFW];
  assign exp_c   = in_data[IFW +: IEW];
  assign frac_c  = in_data[IFW-1:0];
  assign sh_full = (IEW+1)'(SH_BASE) - {1'b0, exp_c};
  assign sh_c    = (sh_full > (IEW+1)'(SH_MAX)) ? SH_W'(SH_MAX) : sh_full[SH_W-1:0];

  always_comb begin
    if (&exp_c) begin
      cls_c = (frac_c == '0) ? CLS_INF : CLS_NAN;
    end else if (exp_c == '0 && frac_c == '0) begin
      cls_c = CLS_ZERO;
    end else if (exp_c >= IEW'(OVF_E)) begin
      cls_c = CLS_OVF;
    end else if (exp_c <= IEW'(BIAS_DIFF)) begin
      cls_c = CLS_SUB;
    end else begin
      cls_c = CLS_NORM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_cls   <= CLS_ZERO;
      s1_exp   <= '0;
      s1_sig   <= '0;
      s1_shift <= '0;
      s1_snan  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign  <= sign_c;
        s1_cls   <= cls_c;
        s1_exp   <= OEW'(exp_c - IEW'(BIAS_DIFF));
        s1_sig   <= {(exp_c != '0), frac_c};
        s1_shift <= sh_c;
        s1_snan  <= ~frac_c[IFW-1];
      end
    end
  end
endmodule

// File: rtl/rto_pack.sv
// Stage 2: truncate, force the odd bit on lost precision, pack.
module rto_pack
  import rto_pkg::*;
#(
  parameter int IEW  = DBL_EXP_W,
  parameter int IFW  = DBL_FRAC_W,
  parameter int OEW  = SGL_EXP_W,
  parameter int OFW  = SGL_FRAC_W,
  parameter int SH_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s1_valid,
  input  logic                  s1_sign,
  input  rto_cls_e              s1_cls,
  input  logic [OEW-1:0]        s1_exp,
  input  logic [IFW:0]          s1_sig,
  input  logic [SH_W-1:0]       s1_shift,
  input  logic                  s1_snan,
  output logic                  nxt_valid,
  output logic [FLAG_W-1:0]     nxt_flags,
  output logic                  out_valid,
  output logic [OEW+OFW:0]      out_data
);
  localparam int SIG_W = IFW + 1;
  localparam int OUT_W = OEW + OFW + 1;

  logic [OFW-1:0]   sub_frac;
  logic [SIG_W-1:0] lost_mask;
  logic             sub_lost;
  logic [OFW-1:0]   nrm_frac;
  logic             nrm_lost;
  logic [OUT_W-1:0] res_c;

  assign sub_frac  = OFW'(s1_sig >> s1_shift);
  assign lost_mask = ~({SIG_W{1'b1}} << s1_shift);
  assign sub_lost  = |(s1_sig & lost_mask);
  assign nrm_frac  = s1_sig[IFW-1 -: OFW];
  assign nrm_lost  = |s1_sig[IFW-OFW-1:0];
  assign nxt_valid = s1_valid;

  always_comb begin
    nxt_flags = '0;
    res_c     = '0;
    unique case (s1_cls)
      CLS_ZERO: res_c = {s1_sign, {(OEW+OFW){1'b0}}};
      CLS_INF:  res_c = {s1_sign, {OEW{1'b1}}, {OFW{1'b0}}};
      CLS_NAN: begin
        res_c              = {s1_sign, {OEW{1'b1}}, 1'b1, s1_sig[IFW-2 -: OFW-1]};
        nxt_flags[FLG_INV] = s1_snan;
      end
      CLS_OVF: begin
        res_c              = {s1_sign, {(OEW-1){1'b1}}, 1'b0, {OFW{1'b1}}};
        nxt_flags[FLG_OVF] = 1'b1;
        nxt_flags[FLG_INX] = 1'b1;
      end
      CLS_NORM: begin
        res_c              = {s1_sign, s1_exp, nrm_frac[OFW-1:1], nrm_frac[0] | nrm_lost};
        nxt_flags[FLG_INX] = nrm_lost;
      end
      CLS_SUB: begin
        res_c              = {s1_sign, {OEW{1'b0}}, sub_frac[OFW-1:1], sub_frac[0] | sub_lost};
        nxt_flags[FLG_UDF] = sub_lost;
        nxt_flags[FLG_INX] = sub_lost;
      end
      default: res_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= res_c;
    end
  end
endmodule

// File: rtl/rto_sticky.sv
// Accumulating exception status with clear.
module rto_sticky
  import rto_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          upd,
  input  logic [FW-1:0] new_flags,
  output logic [FW-1:0] flags
);
  logic [FW-1:0] incoming;
  assign incoming = upd ? new_flags : '0;

  always_ff @(posedge clk) begin
    if (rst)        flags <= '0;
    else if (clear) flags <= incoming;
    else            flags <= flags | incoming;
  end
endmodule

// File: rtl/narrow_rto_conv.sv
module narrow_rto_conv
  import rto_pkg::*;
#(
  parameter int IEW = DBL_EXP_W,
  parameter int IFW = DBL_FRAC_W,
  parameter int OEW = SGL_EXP_W,
  parameter int OFW = SGL_FRAC_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [IEW+IFW:0]       in_data,
  input  logic                   flag_clear,
  output logic                   out_valid,
  output logic [OEW+OFW:0]       out_data,
  output logic [FLAG_W-1:0]      flags
);
  localparam int SH_W = $clog2(IFW + 2);

  logic              s1_valid, s1_sign, s1_snan;
  rto_cls_e          s1_cls;
  logic [OEW-1:0]    s1_exp;
  logic [IFW:0]      s1_sig;
  logic [SH_W-1:0]   s1_shift;
  logic              nxt_valid;
  logic [FLAG_W-1:0] nxt_flags;

  rto_classify #(.IEW(IEW), .IFW(IFW), .OEW(OEW), .OFW(OFW), .SH_W(SH_W)) u_cls (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_cls(s1_cls), .s1_exp(s1_exp),
    .s1_sig(s1_sig), .s1_shift(s1_shift), .s1_snan(s1_snan)
  );

  rto_pack #(.IEW(IEW), .IFW(IFW), .OEW(OEW), .OFW(OFW), .SH_W(SH_W)) u_pack (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_cls(s1_cls),
    .s1_exp(s1_exp), .s1_sig(s1_sig), .s1_shift(s1_shift), .s1_snan(s1_snan),
    .nxt_valid(nxt_valid), .nxt_flags(nxt_flags),
    .out_valid(out_valid), .out_data(out_data)
  );

  rto_sticky #(.FW(FLAG_W)) u_sticky (
    .clk(clk), .rst(rst), .clear(flag_clear), .upd(nxt_valid),
    .new_flags(nxt_flags), .flags(flags)
  );
endmodule

// File: rtl/narrow_rto_conv_chk.sv
module narrow_rto_conv_chk #(
  parameter int OEW = 8,
  parameter int OFW = 23,
  parameter int FW  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               flag_clear,
  input logic               out_valid,
  input logic [OEW+OFW:0]   out_data,
  input logic [FW-1:0]      flags
);
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  p_origin_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  p_ovf_inexact_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[2]) |-> flags[0]);

  p_nan_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (&out_data[OFW +: OEW]) && (|out_data[OFW-1:0])) |-> out_data[OFW-1]);

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !flag_clear |=> ((flags & $past(flags)) == $past(flags)));

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !flag_clear |=> (out_valid || $stable(flags)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    flag_clear |=> (out_valid || flags == '0));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && flags == '0 && out_data == '0));
endmodule

bind narrow_rto_conv narrow_rto_conv_chk #(.OEW(OEW), .OFW(OFW), .FW(rto_pkg::FLAG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .flag_clear(flag_clear),
  .out_valid(out_valid), .out_data(out_data), .flags(flags)
);

// File: tb/narrow_rto_conv_test.sv
`timescale 1ns/1ps
module narrow_rto_conv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        flag_clear = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  narrow_rto_conv uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .flag_clear(flag_clear), .out_valid(out_valid), .out_data(out_data), .flags(flags)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clear = 1'b1;
    @(negedge clk); flag_clear = 1'b0;
  endtask

  // single conversion; flags layout {inv, ovf, udf, inx}
  task automatic run_one(input logic [63:0] x, input string req,
                         input logic [31:0] exp_res, input logic [3:0] exp_flg, input bit do_clear);
    if (do_clear) clear_flags();
    @(negedge clk); in_valid = 1'b1; in_data = x;
    @(negedge clk); in_valid = 1'b0;
    check("R1", "out_valid early", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R1", "out_valid", {31'd0, out_valid}, 32'd1);
    check(req, "out_data", out_data, exp_res);
    check(req, "flags", {28'd0, flags}, {28'd0, exp_flg});
  endtask

  task automatic t_reset();
    check("R10", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R10", "reset out_data", out_data, 32'd0);
    check("R10", "reset flags", {28'd0, flags}, 32'd0);
  endtask

  task automatic t_normal();   // R2
    run_one(64'h3FF0000000000000, "R2", 32'h3F800000, 4'b0000, 1'b1);
    run_one(64'h3FF0000000000001, "R2", 32'h3F800001, 4'b0001, 1'b1);
    run_one(64'h3FD5555555555555, "R2", 32'h3EAAAAAB, 4'b0001, 1'b1);
    run_one(64'hC004000000000000, "R2", 32'hC0200000, 4'b0000, 1'b1);
    run_one(64'h47EFFFFFE0000000, "R2", 32'h7F7FFFFF, 4'b0000, 1'b1);
    run_one(64'h3810000000000000, "R2", 32'h00800000, 4'b0000, 1'b1);
  endtask

  task automatic t_overflow(); // R3
    run_one(64'h47F0000000000000, "R3", 32'h7F7FFFFF, 4'b0101, 1'b1);
    run_one(64'hFFE0000000000000, "R3", 32'hFF7FFFFF, 4'b0101, 1'b1);
  endtask

  task automatic t_sub_out();  // R4
    run_one(64'h3800000000000000, "R4", 32'h00400000, 4'b0000, 1'b1);
    run_one(64'h36A0000000000000, "R4", 32'h00000001, 4'b0000, 1'b1);
    run_one(64'h3690000000000000, "R4", 32'h00000001, 4'b0011, 1'b1);
    run_one(64'h3800000000000001, "R4", 32'h00400001, 4'b0011, 1'b1);
    run_one(64'h8010000000000000, "R4", 32'h80000001, 4'b0011, 1'b1);
  endtask

  task automatic t_dbl_sub();  // R5
    run_one(64'h0000000000000001, "R5", 32'h00000001, 4'b0011, 1'b1);
    run_one(64'h800FFFFFFFFFFFFF, "R5", 32'h80000001, 4'b0011, 1'b1);
  endtask

  task automatic t_specials(); // R6
    run_one(64'h0000000000000000, "R6", 32'h00000000, 4'b0000, 1'b1);
    run_one(64'h8000000000000000, "R6", 32'h80000000, 4'b0000, 1'b1);
    run_one(64'h7FF0000000000000, "R6", 32'h7F800000, 4'b0000, 1'b1);
    run_one(64'hFFF0000000000000, "R6", 32'hFF800000, 4'b0000, 1'b1);
  endtask

  task automatic t_nan();      // R7
    run_one(64'h7FF8000000000000, "R7", 32'h7FC00000, 4'b0000, 1'b1);
    run_one(64'h7FF80000E0000000, "R7", 32'h7FC00007, 4'b0000, 1'b1);
    run_one(64'h7FF0000000000001, "R7", 32'h7FC00000, 4'b1000, 1'b1);
    run_one(64'hFFF4000000000000, "R7", 32'hFFE00000, 4'b1000, 1'b1);
  endtask

  task automatic t_sticky();   // R8
    run_one(64'h3FF0000000000001, "R8", 32'h3F800001, 4'b0001, 1'b1);
    run_one(64'h47F0000000000000, "R8", 32'h7F7FFFFF, 4'b0101, 1'b0);
    run_one(64'h7FF0000000000001, "R8", 32'h7FC00000, 4'b1101, 1'b0);
    run_one(64'h3FF0000000000000, "R8", 32'h3F800000, 4'b1101, 1'b0);
  endtask

  task automatic t_clear();    // R9
    clear_flags();
    @(negedge clk);
    check("R9", "flags after clear", {28'd0, flags}, 32'd0);
    run_one(64'h7FF0000000000001, "R9", 32'h7FC00000, 4'b1000, 1'b0);
    @(negedge clk); in_valid = 1'b1; in_data = 64'h3FF0000000000001;
    @(negedge clk); in_valid = 1'b0; flag_clear = 1'b1;
    @(negedge clk); flag_clear = 1'b0;
    check("R9", "same-edge result", out_data, 32'h3F800001);
    check("R9", "same-edge flags", {28'd0, flags}, 32'h1);
  endtask

  task automatic t_stream();   // R1 back-to-back
    clear_flags();
    @(negedge clk); in_valid = 1'b1; in_data = 64'h3FF0000000000000;
    @(negedge clk); in_data = 64'hC004000000000000;
    @(negedge clk); in_data = 64'h7FF0000000000000;
    check("R1", "stream first valid", {31'd0, out_valid}, 32'd1);
    check("R1", "stream first", out_data, 32'h3F800000);
    @(negedge clk); in_valid = 1'b0;
    check("R1", "stream second", out_data, 32'hC0200000);
    @(negedge clk);
    check("R1", "stream third", out_data, 32'h7F800000);
    check("R1", "stream third valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R1", "stream end", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_overflow();
    t_sub_out();
    t_dbl_sub();
    t_specials();
    t_nan();
    t_sticky();
    t_clear();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule